// File: doc/BRIEF.md
# Prioritized Banked Interrupt Controller

A single bank of 32 interrupt lines behind a small memory-mapped register port. Every line carries its own configuration word that chooses level or rising-edge sensing, a 5-bit priority and whether the line is routed to the fast interrupt output or the normal one. Per-line enables come from a mask register, and a single global mask gates whether the bank makes any decision at all.

Two independent arbiters, one per output, select the pending unmasked line with the smallest priority value. The lower line index wins a tie. Once an arbiter has chosen, its output goes high and the chosen line number is frozen in a read-only winner register. The decision does not change until software acknowledges it through the control register.

A bank built with fast routing disabled acts as a second-level bank. Its fast-routing bit always reads zero, and its normal output is wired into one input line of a first-level bank. Software maps a global interrupt number to bank `n >> 5` and line `n & 31`.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset the mask register (0x04) reads all ones, the global mask (0xA0) reads 1, every config word reads 0, both outputs are low and both winner registers read 0.
- R2: A line whose mask bit is 1 is never chosen. A mask bit of 0 lets the line take part in arbitration.
- R3: The config word for line i is at 0x1C + 4*i. Bit 0 routes the line to the fast output, bit 1 selects edge sensing (1) or level sensing (0), bits 6:2 hold the priority, and the word reads back as written.
- R4: Among pending unmasked lines routed to an output, the smallest priority value wins, and equal priorities go to the lower line index. The normal and fast outputs are arbitrated separately.
- R5: The winner registers are 0x10 (normal) and 0x14 (fast). Bits 4:0 give the line and bit 31 is set while a decision is held. The matching output is high exactly while bit 31 is set, and it rises two clock edges after a pending input appears.
- R6: A held decision, together with its output and its line number, does not change while it is unacknowledged, even if a better line becomes pending.
- R7: A write to the control register (0x18) with bit 0 set releases the normal decision, and one with bit 1 set releases the fast decision. Writing 0x3 releases both, and a bit written as 0 leaves its decision untouched.
- R8: An edge-sensed line sets its status bit on a rising input and holds it until its decision is acknowledged. A level-sensed line's status bit follows the input.
- R9: The status register (0x00) reads the per-line status. A write clears every edge-latched bit whose data bit is 0.
- R10: While global-mask bit 0 is 1, no new decision is taken. Writing 0 lets arbitration proceed.
- R11: With FIQ_EN = 0, config bit 0 is stored as 0 and the fast output never rises.
- R12: When a second-level bank's normal output drives a first-level line, the cascaded request reaches the first-level output only while that line is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears one cycle later |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_src | input | NUM_LINES | Raw interrupt request lines |
| irq_out | output | 1 | Normal interrupt request, held until acknowledged |
| fiq_out | output | 1 | Fast interrupt request, held until acknowledged |

## Verification
The bench goes after priority ties, where an arbiter that compares with less-or-equal would hand the line to the higher index, and after a better line that arrives while a decision is held, where a design without the lock would change the reported winner. It also acknowledges one output while the other is held, which catches decode that releases both. It fires single-cycle edge pulses that must survive until acknowledged or cleared through a status write, and a latch cleared on the falling edge would lose them. Global-mask gating, forced-off fast routing in a second-level bank and a cascaded request blocked by a set mask bit round out the directed cases, and randomized patterns of masks, priorities and routing are scored against a bench model of the arbitration.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int PRIO_W = 5;

  localparam logic [7:0] OFS_STATUS   = 8'h00;
  localparam logic [7:0] OFS_MASK     = 8'h04;
  localparam logic [7:0] OFS_IRQ_WIN  = 8'h10;
  localparam logic [7:0] OFS_FIQ_WIN  = 8'h14;
  localparam logic [7:0] OFS_CTRL     = 8'h18;
  localparam logic [7:0] OFS_CFG_BASE = 8'h1C;
  localparam logic [7:0] OFS_GMASK    = 8'hA0;

  // Per-line configuration word: priority in 6:2, edge select in 1, fast route in 0
  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic              edge_trig;
    logic              to_fiq;
  } line_cfg_t;
endpackage

// File: rtl/irq_line_status.sv
module irq_line_status #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] src,
  input  logic [NUM_LINES-1:0] edge_mode,
  input  logic [NUM_LINES-1:0] clr_edge,
  input  logic                 wr_status,
  input  logic [NUM_LINES-1:0] wr_data,
  output logic [NUM_LINES-1:0] status
);
  logic [NUM_LINES-1:0] src_q, src_qq, edge_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      src_qq <= '0;
    end else begin
      src_q  <= src;
      src_qq <= src_q;
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)
        edge_lat[i] <= 1'b0;
      else if (edge_mode[i] && src_q[i] && !src_qq[i])
        edge_lat[i] <= 1'b1;
      else if (clr_edge[i] || (wr_status && !wr_data[i]))
        edge_lat[i] <= 1'b0;
    end
    assign status[i] = edge_mode[i] ? edge_lat[i] : src_q[i];
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             cand,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  output logic                             found,
  output logic [LINE_W-1:0]                win_id
);
  logic [PRIO_W-1:0] best;

  // Strict less-than keeps the lower index on equal priority
  always_comb begin
    found  = 1'b0;
    win_id = '0;
    best   = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (cand[i] && (!found || prio[i] < best)) begin
        found  = 1'b1;
        best   = prio[i];
        win_id = LINE_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_decision.sv
module irq_decision #(
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              found,
  input  logic [LINE_W-1:0] pick,
  input  logic              ack,
  output logic              active,
  output logic [LINE_W-1:0] id
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      id     <= '0;
    end else if (ack) begin
      active <= 1'b0;
    end else if (!active && enable && found) begin
      active <= 1'b1;
      id     <= pick;
    end
  end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit FIQ_EN    = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] irq_src,
  output logic                 irq_out,
  output logic                 fiq_out
);
  localparam int LINE_W  = $clog2(NUM_LINES);
  localparam int CFG_END = int'(OFS_CFG_BASE) + 4 * NUM_LINES;
  localparam int CFG_W   = $bits(line_cfg_t);
  localparam logic [ADDR_W-1:0] A_STATUS  = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_IRQ_WIN = ADDR_W'(OFS_IRQ_WIN);
  localparam logic [ADDR_W-1:0] A_FIQ_WIN = ADDR_W'(OFS_FIQ_WIN);
  localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG     = ADDR_W'(OFS_CFG_BASE);
  localparam logic [ADDR_W-1:0] A_GMASK   = ADDR_W'(OFS_GMASK);

  line_cfg_t                        cfg_q [NUM_LINES];
  logic [NUM_LINES-1:0]             mask_q;
  logic                             gmask_r;
  logic [NUM_LINES-1:0]             status, pending, irq_cand, fiq_cand;
  logic [NUM_LINES-1:0]             edge_mode, to_fiq, clr_edge;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_v;
  logic                             cfg_hit, ack_irq, ack_fiq, wr_status;
  logic [ADDR_W-1:0]                cfg_off;
  logic [LINE_W-1:0]                cfg_idx;
  logic                             irq_found, fiq_found, irq_active, fiq_active;
  logic [LINE_W-1:0]                irq_pick, fiq_pick, irq_id, fiq_id;
  logic                             unused_bits;

  // Address decode
  assign cfg_hit   = (int'(bus_addr) >= int'(OFS_CFG_BASE)) && (int'(bus_addr) < CFG_END)
                     && (bus_addr[1:0] == 2'b00);
  assign cfg_off   = bus_addr - A_CFG;
  assign cfg_idx   = cfg_off[LINE_W+1:2];
  assign ack_irq   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
  assign ack_fiq   = bus_wr && (bus_addr == A_CTRL) && bus_wdata[1];
  assign wr_status = bus_wr && (bus_addr == A_STATUS);
  assign unused_bits = ^cfg_off;

  // Per-line configuration words
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[i] <= '0;
      else if (bus_wr && cfg_hit && (cfg_idx == LINE_W'(i)))
        cfg_q[i] <= '{prio:      bus_wdata[CFG_W-1:2],
                      edge_trig: bus_wdata[1],
                      to_fiq:    FIQ_EN ? bus_wdata[0] : 1'b0};
    end
    assign edge_mode[i] = cfg_q[i].edge_trig;
    assign to_fiq[i]    = cfg_q[i].to_fiq;
    assign prio_v[i]    = cfg_q[i].prio;
  end

  // Mask and global mask
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      gmask_r <= 1'b1;
    end else if (bus_wr) begin
      if (bus_addr == A_MASK)  mask_q  <= bus_wdata[NUM_LINES-1:0];
      if (bus_addr == A_GMASK) gmask_r <= bus_wdata[0];
    end
  end

  // Edge latches released by the acknowledge of the line they won for
  always_comb begin
    clr_edge = '0;
    if (ack_irq && irq_active) clr_edge[irq_id] = 1'b1;
    if (ack_fiq && fiq_active) clr_edge[fiq_id] = 1'b1;
  end

  irq_line_status #(.NUM_LINES(NUM_LINES)) u_status (
    .clk(clk), .rst(rst), .src(irq_src), .edge_mode(edge_mode),
    .clr_edge(clr_edge), .wr_status(wr_status),
    .wr_data(bus_wdata[NUM_LINES-1:0]), .status(status)
  );

  assign pending  = status & ~mask_q;
  assign irq_cand = pending & ~to_fiq;
  assign fiq_cand = pending & to_fiq;

  prio_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_irq_arb (
    .cand(irq_cand), .prio(prio_v), .found(irq_found), .win_id(irq_pick)
  );
  prio_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_fiq_arb (
    .cand(fiq_cand), .prio(prio_v), .found(fiq_found), .win_id(fiq_pick)
  );

  irq_decision #(.LINE_W(LINE_W)) u_irq_dec (
    .clk(clk), .rst(rst), .enable(!gmask_r), .found(irq_found), .pick(irq_pick),
    .ack(ack_irq), .active(irq_active), .id(irq_id)
  );
  irq_decision #(.LINE_W(LINE_W)) u_fiq_dec (
    .clk(clk), .rst(rst), .enable(!gmask_r && FIQ_EN), .found(fiq_found),
    .pick(fiq_pick), .ack(ack_fiq), .active(fiq_active), .id(fiq_id)
  );

  assign irq_out = irq_active;
  assign fiq_out = fiq_active;

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (cfg_hit) begin
        bus_rdata <= DATA_W'(cfg_q[cfg_idx]);
      end else begin
        case (bus_addr)
          A_STATUS:  bus_rdata <= DATA_W'(status);
          A_MASK:    bus_rdata <= DATA_W'(mask_q);
          A_GMASK:   bus_rdata <= DATA_W'(gmask_r);
          A_IRQ_WIN: bus_rdata <= {irq_active, {(DATA_W-1-LINE_W){1'b0}}, irq_id};
          A_FIQ_WIN: bus_rdata <= {fiq_active, {(DATA_W-1-LINE_W){1'b0}}, fiq_id};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter bit FIQ_EN    = 1'b1,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 irq_out,
  input logic                 fiq_out,
  input logic [LINE_W-1:0]    irq_id,
  input logic [LINE_W-1:0]    fiq_id,
  input logic [NUM_LINES-1:0] mask_q,
  input logic                 gmask_r
);
  logic                 ack_i, ack_f;
  logic [NUM_LINES-1:0] mask_prev;

  assign ack_i = bus_wr && (bus_addr == ADDR_W'(8'h18)) && bus_wdata[0];
  assign ack_f = bus_wr && (bus_addr == ADDR_W'(8'h18)) && bus_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) mask_prev <= '1;
    else     mask_prev <= mask_q;
  end

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack_i) |=> irq_out);
  p_irq_id_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !ack_i) |=> $stable(irq_id));
  p_fiq_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (fiq_out && !ack_f) |=> (fiq_out && $stable(fiq_id)));
  p_irq_release_r7: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !irq_out);
  p_fiq_release_r7: assert property (@(posedge clk) disable iff (rst)
    ack_f |=> !fiq_out);
  p_gmask_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (gmask_r && !irq_out && !fiq_out) |=> (!irq_out && !fiq_out));
  p_no_fast_lvl2_r11: assert property (@(posedge clk) disable iff (rst)
    (FIQ_EN == 1'b0) |-> !fiq_out);
  p_masked_never_wins_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> !mask_prev[irq_id]);
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIQ_EN(FIQ_EN)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .irq_out(irq_out), .fiq_out(fiq_out), .irq_id(irq_id), .fiq_id(fiq_id),
  .mask_q(mask_q), .gmask_r(gmask_r)
);

// File: tb/irq_bank_ctrl_bench.sv
`timescale 1ns/1ps
module irq_bank_ctrl_bench;
  localparam logic [7:0] STAT = 8'h00, MSK = 8'h04, IWIN = 8'h10, FWIN = 8'h14;
  localparam logic [7:0] CTRL = 8'h18, CFG = 8'h1C, GMSK = 8'hA0;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bwr = 1'b0, brd = 1'b0, bsel = 1'b0, casc_en = 1'b0;
  logic [7:0]  baddr = '0;
  logic [31:0] bwdata = '0, rdata1, rdata2;
  logic [31:0] src1 = '0, src2 = '0, lvl1_src;
  logic        irq1, fiq1, irq2, fiq2;
  int          n_chk = 0, n_fail = 0;
  int          b_prio [32];
  bit          b_fiq  [32];

  always #2 clk = ~clk;

  assign lvl1_src = {src1[31:1], casc_en ? irq2 : src1[0]};

  irq_bank_ctrl u_irq_bank_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bwr && !bsel), .bus_rd(brd && !bsel),
    .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rdata1),
    .irq_src(lvl1_src), .irq_out(irq1), .fiq_out(fiq1)
  );
  irq_bank_ctrl #(.FIQ_EN(1'b0)) u_lvl2 (
    .clk(clk), .rst(rst), .bus_wr(bwr && bsel), .bus_rd(brd && bsel),
    .bus_addr(baddr), .bus_wdata(bwdata), .bus_rdata(rdata2),
    .irq_src(src2), .irq_out(irq2), .fiq_out(fiq2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bsel = b; bwr = 1'b1; baddr = a; bwdata = d;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bsel = b; brd = 1'b1; baddr = a;
    @(negedge clk); brd = 1'b0; d = b ? rdata2 : rdata1;
  endtask

  task automatic setcfg(input bit b, input int line, input bit f, input bit e, input int p);
    wr(b, CFG + 8'(line * 4), 32'((p << 2) | (int'(e) << 1) | int'(f)));
    if (!b) begin b_prio[line] = p; b_fiq[line] = f; end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiesce();
    src1 = '0;
    wr(0, MSK, 32'hFFFF_FFFF);
    wr(0, STAT, 32'h0);
    wr(0, CTRL, 32'h3);
    settle(3);
  endtask

  function automatic logic [31:0] exp_win(input logic [31:0] pend, input bit want_fiq);
    int best = 99, id = 0;
    bit found = 0;
    for (int i = 0; i < 32; i++)
      if (pend[i] && (b_fiq[i] == want_fiq) && b_prio[i] < best) begin
        best = b_prio[i]; id = i; found = 1;
      end
    return found ? (32'h8000_0000 | 32'(id)) : 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, m, s, e;
    void'($urandom(32'h5EED_0421));
    for (int i = 0; i < 32; i++) begin b_prio[i] = 0; b_fiq[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(2);

    // R1 reset state
    rd(0, MSK, v);  chk("R1 mask", v, 32'hFFFF_FFFF);
    rd(0, GMSK, v); chk("R1 gmask", v, 32'h1);
    rd(0, CFG + 8'd28, v); chk("R1 cfg7", v, 32'h0);
    rd(0, IWIN, v); chk("R1 irq win", v, 32'h0);
    rd(0, FWIN, v); chk("R1 fiq win", v, 32'h0);
    chk("R1 outputs", {30'b0, irq1, fiq1}, 32'h0);

    // R10 global mask blocks decisions
    setcfg(0, 3, 0, 0, 2);
    wr(0, MSK, ~32'h8);
    src1[3] = 1'b1;
    settle(5);
    chk("R10 gated irq_out", {31'b0, irq1}, 32'h0);
    wr(0, GMSK, 32'h0);
    settle(3);
    chk("R10 released irq_out", {31'b0, irq1}, 32'h1);
    rd(0, IWIN, v); chk("R10 win line3", v, 32'h8000_0003);

    // R3 config readback
    wr(0, CFG + 8'd36, 32'h7F);
    rd(0, CFG + 8'd36, v); chk("R3 cfg9 readback", v, 32'h7F);
    setcfg(0, 9, 0, 0, 0);

    // R6 freeze, R7 release, R4 priority
    quiesce();
    setcfg(0, 10, 0, 0, 8);
    setcfg(0, 11, 0, 0, 1);
    wr(0, MSK, ~32'h0C00);
    src1[10] = 1'b1;
    settle(4);
    rd(0, IWIN, v); chk("R5 win line10", v, 32'h8000_000A);
    src1[11] = 1'b1;
    settle(4);
    rd(0, IWIN, v); chk("R6 frozen line10", v, 32'h8000_000A);
    wr(0, CTRL, 32'h1);
    settle(3);
    rd(0, IWIN, v); chk("R4 better prio line11", v, 32'h8000_000B);

    // R4 tie goes to lower index
    quiesce();
    setcfg(0, 12, 0, 0, 3);
    setcfg(0, 20, 0, 0, 3);
    wr(0, MSK, ~32'h0010_1000);
    src1[20] = 1'b1; src1[12] = 1'b1;
    settle(4);
    rd(0, IWIN, v); chk("R4 tie line12", v, 32'h8000_000C);

    // R4 separate arbitration, R7 selective acknowledge
    quiesce();
    setcfg(0, 2, 1, 0, 0);
    setcfg(0, 3, 0, 0, 0);
    wr(0, MSK, ~32'hC);
    src1[2] = 1'b1; src1[3] = 1'b1;
    settle(4);
    rd(0, FWIN, v); chk("R4 fiq win line2", v, 32'h8000_0002);
    rd(0, IWIN, v); chk("R4 irq win line3", v, 32'h8000_0003);
    src1[3] = 1'b0;
    settle(3);
    wr(0, CTRL, 32'h1);
    settle(3);
    chk("R7 irq acked", {31'b0, irq1}, 32'h0);
    rd(0, FWIN, v); chk("R7 fiq kept", v, 32'h8000_0002);
    src1[3] = 1'b1;
    settle(4);
    src1[2] = 1'b0; src1[3] = 1'b0;
    settle(3);
    wr(0, CTRL, 32'h3);
    settle(3);
    chk("R7 both acked", {30'b0, irq1, fiq1}, 32'h0);

    // R8 edge latch, level follow
    quiesce();
    setcfg(0, 5, 0, 1, 0);
    wr(0, MSK, ~32'h20);
    @(negedge clk); src1[5] = 1'b1;
    @(negedge clk); src1[5] = 1'b0;
    settle(3);
    rd(0, STAT, v); chk("R8 edge latched", v & 32'h20, 32'h20);
    rd(0, IWIN, v); chk("R8 edge win line5", v, 32'h8000_0005);
    wr(0, CTRL, 32'h1);
    settle(3);
    rd(0, STAT, v); chk("R8 edge cleared by ack", v & 32'h20, 32'h0);
    chk("R8 irq low after ack", {31'b0, irq1}, 32'h0);
    setcfg(0, 6, 0, 0, 4);
    src1[6] = 1'b1; settle(3);
    rd(0, STAT, v); chk("R8 level high", v & 32'h40, 32'h40);
    src1[6] = 1'b0; settle(3);
    rd(0, STAT, v); chk("R8 level low", v & 32'h40, 32'h0);

    // R9 status write clears edge latch; R2 masked line not chosen
    quiesce();
    @(negedge clk); src1[5] = 1'b1;
    @(negedge clk); src1[5] = 1'b0;
    settle(3);
    rd(0, STAT, v); chk("R9 latched while masked", v & 32'h20, 32'h20);
    chk("R2 masked no irq", {31'b0, irq1}, 32'h0);
    wr(0, STAT, 32'h0);
    rd(0, STAT, v); chk("R9 cleared by write", v & 32'h20, 32'h0);

    // R11 second-level bank drops fast routing
    wr(1, CFG + 8'd4, 32'h7F);
    rd(1, CFG + 8'd4, v); chk("R11 fiq bit forced", v, 32'h7E);
    wr(1, GMSK, 32'h0);
    wr(1, MSK, ~32'h2);
    src2[1] = 1'b1;
    settle(4);
    chk("R11 lvl2 irq_out", {31'b0, irq2}, 32'h1);
    chk("R11 lvl2 fiq_out", {31'b0, fiq2}, 32'h0);

    // R12 cascade passes only through an unmasked line
    quiesce();
    casc_en = 1'b1;
    setcfg(0, 0, 0, 0, 0);
    settle(4);
    chk("R12 masked cascade", {31'b0, irq1}, 32'h0);
    wr(0, MSK, ~32'h1);
    settle(4);
    chk("R12 cascade irq_out", {31'b0, irq1}, 32'h1);
    rd(0, IWIN, v); chk("R12 cascade win line0", v, 32'h8000_0000);
    casc_en = 1'b0;

    // R2 R4 R5 randomized arbitration
    quiesce();
    for (int it = 0; it < 48; it++) begin
      if (it % 8 == 0)
        for (int l = 0; l < 32; l++)
          setcfg(0, l, ($urandom % 4) == 0, 0, int'($urandom % 4));
      m = (it % 3 == 0) ? $urandom : ($urandom & $urandom);
      s = $urandom;
      wr(0, MSK, m);
      src1 = s;
      settle(3);
      wr(0, CTRL, 32'h3);
      settle(3);
      e = exp_win(s & ~m, 0);
      rd(0, IWIN, v);
      chk("R4 random irq win", e[31] ? v : (v & 32'h8000_0000), e);
      chk("R5 random irq_out", {31'b0, irq1}, {31'b0, e[31]});
      e = exp_win(s & ~m, 1);
      rd(0, FWIN, v);
      chk("R2 random fiq win", e[31] ? v : (v & 32'h8000_0000), e);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule